// File: doc/BRIEF.md
# Parallel ROM Read Timing Controller

This block sits on the host side of an asynchronous 64K x 8 parallel read-only memory. The memory has two active-low control lines, one to select the chip and one to turn on its output drivers. The host raises a request together with a 16-bit address while the controller reports ready. The controller then drives the address and selects the chip. It waits long enough for the address path and the chip-select path to settle, and only then turns on the memory outputs. It samples the byte, presents it with a one-cycle valid strobe, and releases both control lines in that same cycle.

The controller does not use a single fixed wait count. It enforces the three read latencies of the memory separately: address to data, chip select to data, and output enable to data. It then enforces a bus-float recovery interval before it accepts the next request. Every interval is derived at elaboration time from nanosecond parameters and the clock period. A grade parameter picks the nanosecond defaults: 45/45/20/20 ns for the fast grade and 70/70/30/25 ns for the slow grade.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is held and right after it, `mem_ce_n_o` and `mem_oe_n_o` are 1, `rvalid_o` is 0 and `ready_o` is 1.
- R2: A request is taken only in a cycle where `ready_o` is 1. A request raised while the controller is busy is dropped: it yields no second strobe, the returned byte is unchanged, and no new access starts once the controller is idle again.
- R3: In the cycle after a request is taken, `mem_addr_o` carries the requested address and `mem_ce_n_o` is 0. The address stays unchanged for as long as `mem_ce_n_o` is 0.
- R4: Each interval in clocks is ceil(ns / CLK_NS), with a floor of 1. This gives CA (address), CC (chip select), CO (output enable) and CF (float). `mem_oe_n_o` falls exactly NA = max(max(CA, CC) - CO, 1) cycles after `mem_ce_n_o` falls.
- R5: `mem_oe_n_o` stays 0 for CO + 1 cycles. `mem_ce_n_o` stays 0 for NA + CO + 1 cycles.
- R6: `rvalid_o` rises in the same cycle that both enables return to 1, and both enables were 0 in the cycle before.
- R7: `rdata_o` equals the byte the memory drove on `mem_data_i` during the last cycle in which both enables were 0.
- R8: After the enables rise, `ready_o` stays 0 for CF cycles. While `ready_o` is 1, both enables are 1. With a request held high continuously, `mem_ce_n_o` stays high for exactly CF + 1 cycles between two accesses.
- R9: `mem_oe_n_o` is never 0 while `mem_ce_n_o` is 1.
- R10: `rvalid_o` is high for exactly one cycle per accepted request. `rdata_o` holds its value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken when ready_o is 1 |
| addr_i | input | 16 | Byte address of the request |
| ready_o | output | 1 | Controller idle, a request can be taken |
| rdata_o | output | 8 | Captured byte |
| rvalid_o | output | 1 | One-cycle strobe marking rdata_o as new |
| mem_addr_o | output | 16 | Address lines to the memory |
| mem_ce_n_o | output | 1 | Chip select to the memory, active low |
| mem_oe_n_o | output | 1 | Output enable to the memory, active low |
| mem_data_i | input | 8 | Data lines from the memory |

## Verification
Two situations are the hardest to reach from the ports. The first is a memory that answers too early: a real part would simply show the correct byte a little later. The bench memory model therefore counts, on every falling clock edge, how long the address, the chip select and the output enable have each been stable. It drives a poison byte until all three latencies are met, so any shortened wait shows up as wrong data. The second is a request that arrives mid-access. That is provoked by pulsing the request during the address phase. A request is also held high across two back-to-back accesses, which measures the float gap directly at the chip-select pin.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_OE,
        ST_CAPT,
        ST_REL
    } rd_state_e;

    // Converts a delay in ns to whole clocks, rounding up, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_rd_timer.sv
module prom_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // R4
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !done_o);

endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 4,
    parameter int N_ADDR = 1,
    parameter int N_OE   = 1,
    parameter int N_DF   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              timer_done_i,
    output logic              ready_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              capt_o
);

    typedef struct packed {
        rd_state_e         st;
        logic              ce_n;
        logic              oe_n;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        load_o     = 1'b0;
        load_val_o = '0;
        capt_o     = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.st     = ST_ADDR;
                    s_d.addr   = addr_i;
                    s_d.ce_n   = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(N_ADDR - 1);
                end
            end
            ST_ADDR: begin
                if (timer_done_i) begin
                    s_d.st     = ST_OE;
                    s_d.oe_n   = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(N_OE - 1);
                end
            end
            ST_OE: begin
                if (timer_done_i) begin
                    s_d.st = ST_CAPT;
                end
            end
            ST_CAPT: begin
                capt_o     = 1'b1;
                s_d.st     = ST_REL;
                s_d.ce_n   = 1'b1;
                s_d.oe_n   = 1'b1;
                load_o     = 1'b1;
                load_val_o = CNT_W'(N_DF - 1);
            end
            ST_REL: begin
                if (timer_done_i) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: begin
                s_d.st   = ST_IDLE;
                s_d.ce_n = 1'b1;
                s_d.oe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.ce_n <= 1'b1;
            s_q.oe_n <= 1'b1;
            s_q.addr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = (s_q.st == ST_IDLE);
    assign ce_n_o  = s_q.ce_n;
    assign oe_n_o  = s_q.oe_n;
    assign addr_o  = s_q.addr;

    // R9
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> !ce_n_o);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_o));

    // R8
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (ce_n_o && oe_n_o));

endmodule

// File: rtl/prom_rd_capture.sv
module prom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capt_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = capt_i;
        if (capt_i) begin
            c_d.data = mem_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rdata_o  = c_q.data;
    assign rvalid_o = c_q.vld;

    // R10
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int CLK_NS     = 4,
    parameter bit FAST_GRADE = 1'b0,
    parameter int T_ACC_NS   = FAST_GRADE ? 45 : 70,
    parameter int T_CE_NS    = FAST_GRADE ? 45 : 70,
    parameter int T_OE_NS    = FAST_GRADE ? 20 : 30,
    parameter int T_DF_NS    = FAST_GRADE ? 20 : 25,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    input  logic [DATA_W-1:0] mem_data_i
);

    localparam int C_ACC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int C_CE   = ns_to_cyc(T_CE_NS, CLK_NS);
    localparam int C_OE   = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int C_DF   = ns_to_cyc(T_DF_NS, CLK_NS);
    localparam int N_ADDR = imax(imax(C_ACC, C_CE) - C_OE, 1);
    localparam int N_MAX  = imax(imax(N_ADDR, C_OE), C_DF);
    localparam int CNT_W  = imax($clog2(N_MAX + 1), 1);

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             capt;

    prom_rd_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .N_ADDR (N_ADDR),
        .N_OE   (C_OE),
        .N_DF   (C_DF)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .addr_i       (addr_i),
        .timer_done_i (t_done),
        .ready_o      (ready_o),
        .ce_n_o       (mem_ce_n_o),
        .oe_n_o       (mem_oe_n_o),
        .addr_o       (mem_addr_o),
        .load_o       (t_load),
        .load_val_o   (t_val),
        .capt_o       (capt)
    );

    prom_rd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .done_o     (t_done)
    );

    prom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capt_i     (capt),
        .mem_data_i (mem_data_i),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

    // R6
    release_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (mem_ce_n_o && mem_oe_n_o && $past(!mem_ce_n_o && !mem_oe_n_o)));

endmodule

// File: tb/sim_prom_rd_ctrl.sv
module sim_prom_rd_ctrl;

    localparam int CLK = 4;
    localparam int TACC = 70, TCE = 70, TOE = 30, TDF = 25;
    localparam int CA = (TACC + CLK - 1) / CLK;
    localparam int CC = (TCE + CLK - 1) / CLK;
    localparam int CO = (TOE + CLK - 1) / CLK;
    localparam int CF = (TDF + CLK - 1) / CLK;
    localparam int NA = ((CA > CC ? CA : CC) - CO) < 1 ? 1 : ((CA > CC ? CA : CC) - CO);
    localparam int KV = NA + CO + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  mem_data;
    logic        ready, rvalid, ce_n, oe_n;
    logic [7:0]  rdata;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK / 2) clk = ~clk;

    prom_rd_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .ready_o    (ready),
        .rdata_o    (rdata),
        .rvalid_o   (rvalid),
        .mem_addr_o (mem_addr),
        .mem_ce_n_o (ce_n),
        .mem_oe_n_o (oe_n),
        .mem_data_i (mem_data)
    );

    function automatic logic [7:0] rom(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    // Memory model: poison byte until every latency has elapsed.
    int ce_age = 0, oe_age = 0, a_age = 0;
    logic [15:0] last_a = '0;
    always @(negedge clk) begin
        ce_age = ce_n ? 0 : ce_age + 1;
        oe_age = oe_n ? 0 : oe_age + 1;
        a_age  = (mem_addr != last_a) ? 1 : a_age + 1;
        last_a = mem_addr;
        if (!ce_n && !oe_n && ce_age * CLK - 2 >= TCE && oe_age * CLK - 2 >= TOE
            && a_age * CLK - 2 >= TACC)
            mem_data = rom(mem_addr);
        else
            mem_data = 8'hEE;
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<200000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk(ce_n == 1'b1 && oe_n == 1'b1, "R1 enables in reset", {ce_n, oe_n}, 3);
        chk(rvalid == 1'b0 && ready == 1'b1, "R1 valid/ready in reset", {rvalid, ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && !rvalid && ready, "R1 after reset",
            {ce_n, oe_n, rvalid, ready}, 4'b1101);
    endtask

    // One read; optionally pulse a second request at negedge intr_k (R2).
    task automatic t_read(input logic [15:0] a, input int intr_k);
        int ce_bad = -1, oe_bad = -1, rv_bad = -1, rd_bad = -1;
        logic [7:0] got = '0;
        while (!ready) @(negedge clk);
        req = 1'b1; addr = a;
        for (int k = 0; k <= KV + CF; k++) begin
            @(negedge clk);
            req = 1'b0;
            if (k == intr_k) begin req = 1'b1; addr = ~a; end
            if (k == 0) chk(mem_addr == a, "R3 address driven", mem_addr, a);
            if (ce_bad < 0 && ce_n != !(k < KV)) ce_bad = k;
            if (oe_bad < 0 && oe_n != !(k >= NA && k < KV)) oe_bad = k;
            if (rv_bad < 0 && rvalid != (k == KV)) rv_bad = k;
            if (rd_bad < 0 && ready != (k >= KV + CF)) rd_bad = k;
            if (k == KV) got = rdata;
        end
        req = 1'b0;
        chk(ce_bad < 0, "R5 chip select window (first bad cycle)", ce_bad, -1);
        chk(oe_bad < 0, "R4 output enable window (first bad cycle)", oe_bad, -1);
        chk(rv_bad < 0, "R6 valid strobe cycle (first bad cycle)", rv_bad, -1);
        chk(rd_bad < 0, "R8 ready recovery (first bad cycle)", rd_bad, -1);
        chk(got == rom(a), "R7 captured byte", got, rom(a));
    endtask

    task automatic t_busy_ignored();
        int extra = 0;
        t_read(16'h1234, 4);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!ce_n || rvalid) extra++;
        end
        chk(extra == 0, "R2 busy request dropped", extra, 0);
        chk(rdata == rom(16'h1234), "R2 byte unchanged", rdata, rom(16'h1234));
    endtask

    task automatic t_hold();
        logic [7:0] v;
        int moved = 0;
        v = rdata;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rdata != v || rvalid) moved++;
        end
        chk(moved == 0, "R10 rdata holds, no stray strobe", moved, 0);
    endtask

    task automatic t_back_to_back();
        int gap = 0, strobes = 0, rv1 = -1, rv2 = -1;
        logic [7:0] d1 = '0, d2 = '0;
        while (!ready) @(negedge clk);
        req = 1'b1; addr = 16'hFFFF;
        for (int k = 0; k < 2 * KV + CF + 4; k++) begin
            @(negedge clk);
            addr = 16'h0000;
            if (k > 2 * KV + CF - 2) req = 1'b0;
            if (ce_n && k < KV + CF + 3) gap++;
            if (rvalid) begin
                strobes++;
                if (rv1 < 0) begin rv1 = k; d1 = rdata; end
                else begin rv2 = k; d2 = rdata; end
            end
        end
        req = 1'b0;
        chk(gap == CF + 1, "R8 float gap between accesses", gap, CF + 1);
        chk(strobes == 2, "R10 one strobe per access", strobes, 2);
        chk(rv2 - rv1 == KV + CF + 1, "R8 access spacing", rv2 - rv1, KV + CF + 1);
        chk(d1 == rom(16'hFFFF), "R7 first byte", d1, rom(16'hFFFF));
        chk(d2 == rom(16'h0000), "R7 second byte", d2, rom(16'h0000));
    endtask

    initial begin
        t_reset();
        t_read(16'h0000, -1);
        t_hold();
        t_read(16'hFFFF, -1);
        t_read(16'hA5C3, -1);
        t_busy_ignored();
        t_back_to_back();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule